// File: doc/BRIEF.md
# Multi-Mode Block Cipher Chaining Controller

This block sits between a plaintext stream and a fully pipelined 128-bit block cipher core whose latency is a fixed `LAT` clocks. It builds every core input from the plaintext, a running counter or earlier ciphertext. It turns every core result into a ciphertext block, and it returns the ciphertext blocks in input order on a valid/ready stream. Four chaining schemes are available: independent blocks, counter, classic chaining, and a staggered chaining scheme. In the staggered scheme each block is linked to the ciphertext produced `LAT` blocks earlier, so the core stays busy every clock.

A run begins with a start pulse while the controller is idle. The pulse captures the mode and the 128-bit initial vector (which is also the initial counter) and clears all chaining history. Output backpressure is absorbed by a small result buffer. The plaintext side stops accepting whenever that buffer plus the blocks still inside the core could overflow it, so no core result is ever dropped.

Top module: `blkmode_ctrl`

## Requirements
- R1: Out of reset, and until the first accepted start, `pt_ready`, `ct_valid` and `core_req_valid` are all low.
- R2: Mode code 0 (independent blocks): the ciphertext of each block is E(plaintext), where E is the core function.
- R3: Mode code 1 (counter): block k sends counter value C_k to the core and outputs E(C_k) XOR plaintext. C_0 is the loaded vector. Each later value adds one to bits [31:0] modulo 2^32 and leaves bits [127:32] unchanged.
- R4: Mode code 2 (classic chaining): ciphertext k is E(plaintext_k XOR ciphertext_{k-1}), with the loaded vector standing in for ciphertext_{-1}. At most one block is inside the core at any time. With input always offered and output always ready, accepted blocks are spaced exactly `LAT` clocks apart.
- R5: Mode code 3 (staggered chaining): ciphertext k is E(plaintext_k XOR V). V is the loaded vector for k < `LAT` and ciphertext_{k-LAT} otherwise. With `LAT` > 1, block `LAT` therefore differs from classic chaining on the same input.
- R6: Ciphertext leaves in acceptance order and no block is lost under any pattern of `ct_ready`. While `ct_valid` is high and `ct_ready` low, `ct_data` holds.
- R7: A start is taken only when no block is in the core and no ciphertext is waiting; otherwise it is ignored and the running mode continues. `pt_ready` is low in any cycle with `start` high. A taken start restores the counter and all chaining history to the new vector.
- R8: Mode codes 0, 1 and 3 accept one block per clock when input is always offered and output always ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run with `mode_sel` and `iv` (taken only when idle) |
| mode_sel | input | 2 | 0 independent, 1 counter, 2 classic chaining, 3 staggered chaining |
| iv | input | 128 | Initial vector or initial counter |
| pt_valid | input | 1 | Plaintext block offered |
| pt_ready | output | 1 | Plaintext block accepted this cycle when valid |
| pt_data | input | 128 | Plaintext block |
| ct_valid | output | 1 | Ciphertext block available |
| ct_ready | input | 1 | Downstream takes the ciphertext block |
| ct_data | output | 128 | Ciphertext block |
| core_req_valid | output | 1 | Block sent to the cipher core |
| core_req_data | output | 128 | Core input block |
| core_rsp_valid | input | 1 | Core result valid, `LAT` clocks after the request |
| core_rsp_data | input | 128 | Core result |

## Verification
The hardest case to reach is the staggered-chaining bypass. There, a block must be chained to a result that leaves the core in the very cycle the block is issued, and it has to happen under output stalls. Uninterrupted input reaches it in every cycle. Pseudo-random gaps on the input and stalls on the output then move the in-flight count between zero and `LAT`, so the stored and the forwarded chaining paths both get used. An ignored start is issued mid-run while blocks are still in the core, and the following output must stay in the old mode.

// File: rtl/blkmode_pkg.sv
// Shared types and widths for the chaining-mode controller.
package blkmode_pkg;
    localparam int BLK_W = 128;   // cipher block width
    localparam int CTR_W = 32;    // width of the incrementing counter field

    typedef enum logic [1:0] {
        MODE_ECB  = 2'd0,
        MODE_CTR  = 2'd1,
        MODE_CBC  = 2'd2,
        MODE_SCBC = 2'd3
    } chain_mode_e;
endpackage

// File: rtl/bm_delay_line.sv
// Fixed delay of STAGES clocks for a W-bit word. No reset: data only,
// qualified elsewhere by a valid that travels the same number of stages.
module bm_delay_line #(
    parameter int W      = 128,
    parameter int STAGES = 4
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the word one stage along every clock.
    always_ff @(posedge clk) begin
        stage_q[0] <= din;
        for (int i = 1; i < STAGES; i++) begin
            stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/bm_hist_ring.sv
// Ring of DEPTH chaining words indexed by block number modulo DEPTH.
// A load fills every slot with one value; otherwise one slot is written per clock.
module bm_hist_ring #(
    parameter int W     = 128,
    parameter int DEPTH = 4,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          load_all,
    input  logic [W-1:0]  load_val,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] slot_q [DEPTH];

    // Fill on load, else store the returning ciphertext in its slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (load_all) begin
                slot_q[i] <= load_val;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                slot_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/bm_out_fifo.sv
// Result buffer of DEPTH words. Assumes the writer never pushes into a full
// buffer (guaranteed by the credit check in the controller).
module bm_out_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          valid,
    output logic [CW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_pop;

    assign do_pop = pop && (cnt_q != '0);

    // Write the pushed word into storage.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[wp_q] <= push_data;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
            end
            if (do_pop) begin
                rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
            end
            cnt_q <= cnt_q + CW'(push) - CW'(do_pop);
        end
    end

    assign head  = mem_q[rp_q];
    assign valid = (cnt_q != '0);
    assign count = cnt_q;
endmodule

// File: rtl/blkmode_ctrl.sv
// Chaining-mode controller around a pipelined block cipher core of fixed
// latency LAT. Assumes the core accepts one request per clock and returns
// each result exactly LAT clocks later, in order. Modes: independent,
// counter, classic chaining (one block in flight) and staggered chaining
// (block k linked to ciphertext k-LAT).
module blkmode_ctrl
    import blkmode_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode_sel,
    input  logic [BLK_W-1:0] iv,
    input  logic             pt_valid,
    output logic             pt_ready,
    input  logic [BLK_W-1:0] pt_data,
    output logic             ct_valid,
    input  logic             ct_ready,
    output logic [BLK_W-1:0] ct_data,
    output logic             core_req_valid,
    output logic [BLK_W-1:0] core_req_data,
    input  logic             core_rsp_valid,
    input  logic [BLK_W-1:0] core_rsp_data
);
    localparam int BUF_DEPTH = LAT + 2;
    localparam int CNT_W     = $clog2(BUF_DEPTH + 1);
    localparam int IDX_W     = (LAT > 1) ? $clog2(LAT) : 1;

    chain_mode_e      mode_q;
    logic             active_q;
    logic [BLK_W-1:0] ctr_q;
    logic [BLK_W-1:0] chain_q;
    logic [IDX_W-1:0] iss_idx_q, ret_idx_q;
    logic [CNT_W-1:0] inflight_q;
    logic [CNT_W-1:0] fifo_cnt;
    logic [BLK_W-1:0] pt_dly, hist_word, ct_word;
    logic             idle, start_ok, credit_ok, mode_gate, fire;

    // Idle means nothing inside the core and nothing waiting at the output.
    assign idle     = (inflight_q == '0) && (fifo_cnt == '0);
    assign start_ok = start && idle;

    // Space check: buffer must hold every block already in the core plus this one.
    assign credit_ok = ({1'b0, inflight_q} + {1'b0, fifo_cnt}) < (CNT_W + 1)'(BUF_DEPTH);

    // Per-mode issue condition.
    always_comb begin
        unique case (mode_q)
            MODE_CBC:  mode_gate = (inflight_q == '0) ||
                                   ((inflight_q == CNT_W'(1)) && core_rsp_valid);
            MODE_SCBC: mode_gate = (inflight_q < CNT_W'(LAT)) || core_rsp_valid;
            default:   mode_gate = 1'b1;
        endcase
    end

    assign pt_ready = active_q && !start && credit_ok && mode_gate;
    assign fire     = pt_valid && pt_ready;

    // Build the core input from plaintext, counter or chaining value.
    always_comb begin
        unique case (mode_q)
            MODE_CTR:  core_req_data = ctr_q;
            MODE_CBC:  core_req_data = pt_data ^ (core_rsp_valid ? core_rsp_data : chain_q);
            MODE_SCBC: core_req_data = pt_data ^
                       ((core_rsp_valid && (inflight_q == CNT_W'(LAT))) ? core_rsp_data : hist_word);
            default:   core_req_data = pt_data;
        endcase
    end
    assign core_req_valid = fire;

    // Run control, counter, chaining register and block indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            mode_q    <= MODE_ECB;
            ctr_q     <= '0;
            chain_q   <= '0;
            iss_idx_q <= '0;
            ret_idx_q <= '0;
        end else if (start_ok) begin
            active_q  <= 1'b1;
            mode_q    <= chain_mode_e'(mode_sel);
            ctr_q     <= iv;
            chain_q   <= iv;
            iss_idx_q <= '0;
            ret_idx_q <= '0;
        end else begin
            if (fire) begin
                ctr_q     <= {ctr_q[BLK_W-1:CTR_W], ctr_q[CTR_W-1:0] + CTR_W'(1)};
                iss_idx_q <= (iss_idx_q == IDX_W'(LAT - 1)) ? '0 : iss_idx_q + IDX_W'(1);
            end
            if (core_rsp_valid) begin
                chain_q   <= core_rsp_data;
                ret_idx_q <= (ret_idx_q == IDX_W'(LAT - 1)) ? '0 : ret_idx_q + IDX_W'(1);
            end
        end
    end

    // Count blocks inside the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= '0;
        end else begin
            inflight_q <= inflight_q + CNT_W'(fire) - CNT_W'(core_rsp_valid);
        end
    end

    // Plaintext travels beside the core for the counter-mode XOR.
    bm_delay_line #(.W(BLK_W), .STAGES(LAT)) u_pt_dly (
        .clk  (clk),
        .din  (pt_data),
        .dout (pt_dly)
    );

    // Staggered chaining history, one slot per block position modulo LAT.
    bm_hist_ring #(.W(BLK_W), .DEPTH(LAT)) u_hist (
        .clk      (clk),
        .load_all (start_ok),
        .load_val (iv),
        .wr_en    (core_rsp_valid),
        .wr_idx   (ret_idx_q),
        .wr_data  (core_rsp_data),
        .rd_idx   (iss_idx_q),
        .rd_data  (hist_word)
    );

    assign ct_word = (mode_q == MODE_CTR) ? (core_rsp_data ^ pt_dly) : core_rsp_data;

    // Ordered result buffer towards the ciphertext stream.
    bm_out_fifo #(.W(BLK_W), .DEPTH(BUF_DEPTH), .CW(CNT_W)) u_obuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (core_rsp_valid),
        .push_data (ct_word),
        .pop       (ct_ready),
        .head      (ct_data),
        .valid     (ct_valid),
        .count     (fifo_cnt)
    );
endmodule

// File: rtl/blkmode_ctrl_chk.sv
// Property checker for the chaining-mode controller, bound into every instance.
module blkmode_ctrl_chk
    import blkmode_pkg::*;
#(
    parameter int LAT   = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] inflight,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             core_req_valid,
    input logic [BLK_W-1:0] core_req_data,
    input logic             core_rsp_valid,
    input logic             ct_valid,
    input logic             ct_ready,
    input logic [BLK_W-1:0] ct_data
);
    AST_CBC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CBC) |-> (inflight <= CNT_W'(1))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        core_rsp_valid |-> (fifo_cnt < CNT_W'(LAT + 2))); // R6

    AST_CT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_valid && !ct_ready) |=> (ct_valid && $stable(ct_data))); // R6

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight != '0) |=> $stable(mode)); // R7

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_valid && (mode == MODE_CTR) && $past(core_req_valid) && $stable(mode))
        |-> (core_req_data[CTR_W-1:0] == $past(core_req_data[CTR_W-1:0]) + CTR_W'(1))); // R3

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(LAT)); // R8
endmodule

bind blkmode_ctrl blkmode_ctrl_chk #(.LAT(LAT), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode           (mode_q),
    .inflight       (inflight_q),
    .fifo_cnt       (fifo_cnt),
    .core_req_valid (core_req_valid),
    .core_req_data  (core_req_data),
    .core_rsp_valid (core_rsp_valid),
    .ct_valid       (ct_valid),
    .ct_ready       (ct_ready),
    .ct_data        (ct_data)
);

// File: tb/tb_blkmode_ctrl.sv
// Stand-in cipher core: keyed mixing function, fixed latency LAT.
module tb_stub_core #(
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [127:0] in_d,
    output logic         out_v,
    output logic [127:0] out_d
);
    localparam logic [127:0] KEY = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    function automatic logic [127:0] mixf(input logic [127:0] x);
        return {x[100:0], x[127:101]} ^ (x >> 3) ^ KEY;
    endfunction

    logic [LAT-1:0] v_q;
    logic [127:0]   d_q [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= {v_q[LAT-2:0], in_v};
        d_q[0] <= mixf(in_d);
        for (int i = 1; i < LAT; i++) d_q[i] <= d_q[i-1];
    end
    assign out_v = v_q[LAT-1];
    assign out_d = d_q[LAT-1];
endmodule

module tb_blkmode_ctrl;
    localparam int LAT = 4;
    localparam logic [127:0] KEY = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   mode_sel = 2'd0;
    logic [127:0] iv = '0;
    logic         pt_valid = 1'b0;
    logic [127:0] pt_data = '0;
    logic         ct_ready = 1'b0;
    logic         pt_ready, ct_valid, core_req_valid, core_rsp_valid;
    logic [127:0] ct_data, core_req_data, core_rsp_data;

    always #4 clk = ~clk;   // 125 MHz

    blkmode_ctrl #(.LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel), .iv(iv),
        .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_data(pt_data),
        .ct_valid(ct_valid), .ct_ready(ct_ready), .ct_data(ct_data),
        .core_req_valid(core_req_valid), .core_req_data(core_req_data),
        .core_rsp_valid(core_rsp_valid), .core_rsp_data(core_rsp_data)
    );

    tb_stub_core #(.LAT(LAT)) u_core (
        .clk(clk), .rst_n(rst_n), .in_v(core_req_valid), .in_d(core_req_data),
        .out_v(core_rsp_valid), .out_d(core_rsp_data)
    );

    function automatic logic [127:0] mixf(input logic [127:0] x);
        return {x[100:0], x[127:101]} ^ (x >> 3) ^ KEY;
    endfunction

    // Reference model state.
    int           n_cmp = 0, n_bad = 0, cyc = 0;
    logic [31:0]  lfsr = 32'hACE1_2345;
    logic [1:0]   m_mode = 2'd0;
    logic [127:0] m_iv = '0, m_ctr = '0, m_prev = '0;
    logic [127:0] m_hist[$];
    logic [127:0] exp_q[$];
    logic [127:0] run_out[$];
    logic [127:0] req_log[$];
    int           acc_cyc[$];
    int           m_k = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic string mtag(input logic [1:0] m);
        case (m)
            2'd0:    return "R2 independent";
            2'd1:    return "R3 counter";
            2'd2:    return "R4 chaining";
            default: return "R5 staggered";
        endcase
    endfunction

    // One clock: drive at negedge, settle, then model the handshakes of the coming edge.
    task automatic cycle(input bit pv, input logic [127:0] pd, input bit cr,
                         input bit st, input logic [1:0] ms, input logic [127:0] ivv);
        logic [127:0] c, x, e;
        @(negedge clk);
        pt_valid = pv; pt_data = pd; ct_ready = cr; start = st; mode_sel = ms; iv = ivv;
        #1;
        cyc++;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        if (st) begin
            chk(pt_ready == 1'b0, "R7 ready low on start", {127'd0, pt_ready}, 128'd0);
            if (exp_q.size() == 0) begin
                m_mode = ms; m_iv = ivv; m_ctr = ivv; m_prev = ivv; m_k = 0;
                m_hist.delete();
            end
        end
        if (ct_valid && exp_q.size() == 0)
            chk(1'b0, "R6 spurious output", ct_data, 128'd0);
        if (pv && pt_ready) begin
            req_log.push_back(core_req_data);
            case (m_mode)
                2'd0: c = mixf(pd);
                2'd1: begin
                    c = mixf(m_ctr) ^ pd;
                    m_ctr[31:0] = m_ctr[31:0] + 32'd1;
                end
                2'd2: begin
                    c = mixf(pd ^ m_prev);
                    m_prev = c;
                end
                default: begin
                    x = (m_k < LAT) ? m_iv : m_hist[m_k - LAT];
                    c = mixf(pd ^ x);
                end
            endcase
            m_hist.push_back(c);
            m_k++;
            exp_q.push_back(c);
            acc_cyc.push_back(cyc);
        end
        if (ct_valid && cr && exp_q.size() != 0) begin
            e = exp_q.pop_front();
            chk(ct_data == e, {mtag(m_mode), " / R6 order"}, ct_data, e);
            run_out.push_back(ct_data);
        end
    endtask

    function automatic logic [127:0] pt_of(input int k, input logic [31:0] salt);
        return {salt, 32'(k) * 32'h9E37_79B9, ~32'(k), 32'(k) ^ 32'h5A5A_0F0F};
    endfunction

    // One run: start, feed n blocks, then drain.
    task automatic run_stream(input logic [1:0] md, input logic [127:0] ivv, input int n,
                              input logic [31:0] salt, input bit gaps, input bit bp, input bit poke);
        int  acc;
        bit  poked;
        bit  pv, cr, st;
        run_out.delete(); acc_cyc.delete(); req_log.delete();
        cycle(1'b0, '0, 1'b1, 1'b1, md, ivv);
        acc = 0;
        poked = 1'b0;
        for (int guard = 0; guard < 4000 && acc < n; guard++) begin
            pv = gaps ? lfsr[3] | lfsr[9] : 1'b1;
            cr = bp ? lfsr[5] | lfsr[12] : 1'b1;
            st = poke && !poked && acc >= 3 && exp_q.size() != 0;
            if (st) poked = 1'b1;
            cycle(pv, pt_of(acc, salt), cr, st, 2'd1, ~ivv);
            acc = m_k;
        end
        for (int guard = 0; guard < 4000 && exp_q.size() != 0; guard++)
            cycle(1'b0, '0, 1'b1, 1'b0, 2'd0, '0);
        chk(exp_q.size() == 0 && m_k == n, "R6 all blocks delivered", 128'(m_k), 128'(n));
    endtask

    logic [127:0] cbc_keep[$];

    initial begin
        // Reset state (R1)
        for (int i = 0; i < 4; i++) cycle(1'b1, '1, 1'b1, 1'b0, 2'd0, '0);
        @(negedge clk); rst_n = 1'b1;
        cycle(1'b1, '1, 1'b1, 1'b0, 2'd0, '0);
        chk(pt_ready == 1'b0, "R1 pt_ready after reset", {127'd0, pt_ready}, 128'd0);
        chk(ct_valid == 1'b0, "R1 ct_valid after reset", {127'd0, ct_valid}, 128'd0);
        chk(core_req_valid == 1'b0, "R1 core_req_valid after reset", {127'd0, core_req_valid}, 128'd0);
        cycle(1'b0, '0, 1'b1, 1'b0, 2'd0, '0);

        // R2 / R8: independent blocks at full rate
        run_stream(2'd0, 128'h1111, 12, 32'hA1, 1'b0, 1'b0, 1'b0);
        chk(acc_cyc[11] - acc_cyc[0] == 11, "R8 independent rate", 128'(acc_cyc[11] - acc_cyc[0]), 128'd11);

        // R3: counter wrap of the low field, full rate
        run_stream(2'd1, {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'hFFFF_FFFE}, 10, 32'hB2, 1'b0, 1'b0, 1'b0);
        chk(req_log[0] == {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'hFFFF_FFFE}, "R3 first counter",
            req_log[0], {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'hFFFF_FFFE});
        chk(req_log[2] == {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'h0}, "R3 counter wrap",
            req_log[2], {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'h0});
        chk(acc_cyc[9] - acc_cyc[0] == 9, "R8 counter rate", 128'(acc_cyc[9] - acc_cyc[0]), 128'd9);

        // R4: classic chaining, spacing of LAT clocks
        run_stream(2'd2, 128'hC0FFEE, 10, 32'hC3, 1'b0, 1'b0, 1'b0);
        for (int i = 1; i < 10; i++)
            chk(acc_cyc[i] - acc_cyc[i-1] == LAT, "R4 issue spacing",
                128'(acc_cyc[i] - acc_cyc[i-1]), 128'(LAT));
        cbc_keep = run_out;

        // R5: staggered chaining, same input, full rate, diverges at block LAT
        run_stream(2'd3, 128'hC0FFEE, 10, 32'hC3, 1'b0, 1'b0, 1'b0);
        chk(acc_cyc[9] - acc_cyc[0] == 9, "R8 staggered rate", 128'(acc_cyc[9] - acc_cyc[0]), 128'd9);
        chk(run_out[0] == cbc_keep[0], "R5 block 0 equals chaining", run_out[0], cbc_keep[0]);
        chk(run_out[LAT] != cbc_keep[LAT], "R5 block LAT differs from chaining", run_out[LAT], cbc_keep[LAT]);

        // R6 / R7: gaps, backpressure, ignored start mid-run, history restore
        run_stream(2'd0, 128'h5, 20, 32'hD4, 1'b1, 1'b1, 1'b1);
        run_stream(2'd1, 128'hFFFF_FFF0, 20, 32'hE5, 1'b1, 1'b1, 1'b1);
        run_stream(2'd2, 128'h77, 8, 32'hF6, 1'b1, 1'b1, 1'b1);
        run_stream(2'd3, 128'h9999, 24, 32'h17, 1'b1, 1'b1, 1'b1);
        run_stream(2'd3, 128'h4242, 24, 32'h28, 1'b0, 1'b1, 1'b0);
        run_stream(2'd3, 128'hC0FFEE, 10, 32'hC3, 1'b1, 1'b0, 1'b0);
        chk(run_out[LAT] != cbc_keep[LAT], "R7 history restored on start", run_out[LAT], cbc_keep[LAT]);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule